// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block holds a small chip-level configuration space behind two byte-wide ports. One port takes register indices and the other carries register data. The space stays closed until software writes the unlock key to the index port twice in a row. It closes again when software writes the lock key there. While the space is open, software writes an index and then reads or writes the data port to reach the selected register.

A global select register picks one of several logical devices. Four per-device indices then address that device's own bank: an enable flag, a 16-bit base address held as two bytes, and an interrupt line number. Two 16-bit identification values are readable as byte pairs and cannot be written. The enable, base and interrupt values of every device are driven out on flat buses for the address decoders and interrupt routing that sit elsewhere on the chip.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is locked, every bank register and the device select are zero, all exported enable, base and interrupt bits are zero, and the data port reads 0xFF.
- R2: Two consecutive writes of 0x87 to the index port (port select 0) open the space. A single 0x87 does not open it. Any other byte written to the index port while the space is locked restarts the sequence. Data port accesses do not affect the sequence.
- R3: Writing 0xAA to the index port while the space is open locks it. After that, data port reads return 0xFF.
- R4: While the space is locked, writes to the data port (port select 1) change no register and no exported value.
- R5: The index written to the index port stays in effect, so repeated data port accesses reach the same register. The last data write wins.
- R6: Index 0x07 holds the device select as a full byte and reads back what was written. Per-device indices address only the bank of the selected device, and the other banks are left unchanged.
- R7: Per-device indices: 0x30 is the enable, whose bit 0 is stored, read back in bit 0 and exported as dev_en_o[k]. 0x60 is the base high byte and 0x61 the base low byte, exported as dev_base_o[16k+15:16k] = {high, low}. 0x70 is the interrupt number, exported as dev_irq_o[8k+7:8k].
- R8: Indices 0x20/0x21 return the high and low bytes of CHIP_ID, and 0x23/0x24 return the high and low bytes of VENDOR_ID. Writes to these indices are ignored.
- R9: Writes to any unimplemented index are ignored, and reads of such an index return 0x00. This includes 0x87 when it is written as an index while the space is open.
- R10: When the device select is NUM_DEV or more, per-device reads return 0x00 and per-device writes change no bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for one cycle |
| port_sel_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Data port read value for the current index |
| dev_en_o | output | NUM_DEV | Per-device enable |
| dev_base_o | output | 16*NUM_DEV | Per-device base addresses |
| dev_irq_o | output | 8*NUM_DEV | Per-device interrupt numbers |

## Verification
The bench builds the block with NUM_DEV = 4, so device selects 4 through 0xFF fall outside the banks. This makes the out-of-range select rule reachable with small select values. CHIP_ID and VENDOR_ID are set to distinctive non-default values, so a swapped byte or a wrong index shows up directly. Four banks are few enough that all of them are programmed with different values and checked together on the export buses after every scenario, which exposes any write that reaches the wrong bank.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;

  localparam logic       PORT_INDEX = 1'b0;
  localparam logic       PORT_DATA  = 1'b1;

  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_CHIP_HI = 8'h20;
  localparam logic [7:0] IX_CHIP_LO = 8'h21;
  localparam logic [7:0] IX_VEND_HI = 8'h23;
  localparam logic [7:0] IX_VEND_LO = 8'h24;
  localparam logic [7:0] IX_DEV_EN  = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [7:0] IX_IRQ     = 8'h70;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_space_pkg::*;
#(
  parameter logic [7:0] KEY_ON  = 8'h87,
  parameter logic [7:0] KEY_OFF = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic [7:0] index_o
);
  key_state_e state_q, state_d;
  logic [7:0] index_q;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata_i == KEY_ON) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (wdata_i == KEY_ON) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (wdata_i == KEY_OFF) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_LOCKED;
      index_q <= 8'h00;
    end else begin
      state_q <= state_d;
      if (idx_wr_i && state_q == KS_OPEN && wdata_i != KEY_OFF) index_q <= wdata_i;
    end
  end

  assign open_o  = (state_q == KS_OPEN);
  assign index_o = index_q;

  // R2: opening is only ever reached from the half-unlocked state
  p_two_keys_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_OPEN && $past(state_q) != KS_OPEN) |-> $past(state_q) == KS_HALF);

  p_lock_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_OFF) |=> !open_o);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_space_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dat_wr_i,
  input  logic [7:0]             index_i,
  input  logic [7:0]             ldn_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  output logic [NUM_DEV-1:0]     dev_en_o,
  output logic [16*NUM_DEV-1:0]  dev_base_o,
  output logic [8*NUM_DEV-1:0]   dev_irq_o
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             ldn_ok;
  logic [SEL_W-1:0] sel;
  logic             en_q  [NUM_DEV];
  logic [7:0]       hi_q  [NUM_DEV];
  logic [7:0]       lo_q  [NUM_DEV];
  logic [7:0]       irq_q [NUM_DEV];

  assign ldn_ok = (32'(ldn_i) < NUM_DEV);
  assign sel    = ldn_i[SEL_W-1:0];

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    logic wr_k;
    assign wr_k = dat_wr_i && ldn_ok && (sel == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[k]  <= 1'b0;
        hi_q[k]  <= 8'h00;
        lo_q[k]  <= 8'h00;
        irq_q[k] <= 8'h00;
      end else if (wr_k) begin
        if (index_i == IX_DEV_EN)  en_q[k]  <= wdata_i[0];
        if (index_i == IX_BASE_HI) hi_q[k]  <= wdata_i;
        if (index_i == IX_BASE_LO) lo_q[k]  <= wdata_i;
        if (index_i == IX_IRQ)     irq_q[k] <= wdata_i;
      end
    end

    assign dev_en_o[k]           = en_q[k];
    assign dev_base_o[16*k +: 16] = {hi_q[k], lo_q[k]};
    assign dev_irq_o[8*k +: 8]    = irq_q[k];

    p_bank_isolation_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable({en_q[k], hi_q[k], lo_q[k], irq_q[k]}) |-> $past(ldn_i) == 8'(k));
  end

  always_comb begin
    rdata_o = 8'h00;
    if (ldn_ok) begin
      unique case (index_i)
        IX_DEV_EN:  rdata_o = {7'b0, en_q[sel]};
        IX_BASE_HI: rdata_o = hi_q[sel];
        IX_BASE_LO: rdata_o = lo_q[sel];
        IX_IRQ:     rdata_o = irq_q[sel];
        default:    rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_space_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter logic [15:0] CHIP_ID   = 16'h0A15,
  parameter logic [15:0] VENDOR_ID = 16'h3C71,
  parameter logic [7:0]  KEY_ON    = 8'h87,
  parameter logic [7:0]  KEY_OFF   = 8'hAA
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  port_sel_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_DEV-1:0]    dev_en_o,
  output logic [16*NUM_DEV-1:0] dev_base_o,
  output logic [8*NUM_DEV-1:0]  dev_irq_o
);
  logic       open, idx_wr, dat_wr;
  logic [7:0] index, ldn_q, bank_rdata;

  assign idx_wr = wr_i && (port_sel_i == PORT_INDEX);
  assign dat_wr = wr_i && (port_sel_i == PORT_DATA) && open;

  cfg_key_fsm #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_key (
    .clk_i, .rst_ni, .idx_wr_i(idx_wr), .wdata_i,
    .open_o(open), .index_o(index)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ldn_q <= 8'h00;
    else if (dat_wr && index == IX_LDN)  ldn_q <= wdata_i;
  end

  cfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk_i, .rst_ni, .dat_wr_i(dat_wr), .index_i(index), .ldn_i(ldn_q),
    .wdata_i, .rdata_o(bank_rdata), .dev_en_o, .dev_base_o, .dev_irq_o
  );

  always_comb begin
    if (!open) rdata_o = 8'hFF;
    else begin
      unique case (index)
        IX_LDN:     rdata_o = ldn_q;
        IX_CHIP_HI: rdata_o = CHIP_ID[15:8];
        IX_CHIP_LO: rdata_o = CHIP_ID[7:0];
        IX_VEND_HI: rdata_o = VENDOR_ID[15:8];
        IX_VEND_LO: rdata_o = VENDOR_ID[7:0];
        default:    rdata_o = bank_rdata;
      endcase
    end
  end

  p_locked_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |=> ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_o)));

  p_ldn_only_at_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && port_sel_i == PORT_DATA && open && index == IX_LDN) |=> $stable(ldn_q));
endmodule

// File: tb/cfg_index_port_tb_top.sv
`timescale 1ns/1ps
module cfg_index_port_tb_top;
  localparam int          NDEV  = 4;
  localparam logic [15:0] CHIP  = 16'hC3A5;
  localparam logic [15:0] VEND  = 16'h19E7;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr = 1'b0;
  logic                psel = 1'b0;
  logic [7:0]          wd = 8'h00;
  logic [7:0]          rd;
  logic [NDEV-1:0]     en_o;
  logic [16*NDEV-1:0]  base_o;
  logic [8*NDEV-1:0]   irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic        e_en   [NDEV];
  logic [15:0] e_base [NDEV];
  logic [7:0]  e_irq  [NDEV];

  always #4 clk = ~clk;

  cfg_index_port #(.NUM_DEV(NDEV), .CHIP_ID(CHIP), .VENDOR_ID(VEND)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .port_sel_i(psel), .wdata_i(wd),
    .rdata_o(rd), .dev_en_o(en_o), .dev_base_o(base_o), .dev_irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_exports(string req);
    for (int d = 0; d < NDEV; d++) begin
      chk(req, {31'b0, en_o[d]}, {31'b0, e_en[d]});
      chk(req, {16'b0, base_o[16*d +: 16]}, {16'b0, e_base[d]});
      chk(req, {24'b0, irq_o[8*d +: 8]}, {24'b0, e_irq[d]});
    end
  endtask

  task automatic put(logic p, logic [7:0] v);
    psel = p; wd = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] exp);
    psel = 1'b1;
    #1;
    chk(req, {24'b0, rd}, {24'b0, exp});
  endtask

  task automatic reg_wr(logic [7:0] ix, logic [7:0] v);
    put(1'b0, ix); put(1'b1, v);
  endtask

  task automatic reg_rd(string req, logic [7:0] ix, logic [7:0] exp);
    put(1'b0, ix); rd_chk(req, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 locked read", 8'hFF);
    chk_exports("R1 reset exports");
  endtask

  task automatic t_unlock;
    put(1'b0, 8'h87);
    rd_chk("R2 single key", 8'hFF);
    put(1'b0, 8'h55); put(1'b0, 8'h87);
    rd_chk("R2 interrupted key", 8'hFF);
    put(1'b1, 8'h33);             // data write must not disturb the sequence
    put(1'b0, 8'h87);
    put(1'b0, 8'h07);
    rd_chk("R2 open after two keys", 8'h00);
  endtask

  task automatic t_ids;
    reg_rd("R8 chip hi", 8'h20, CHIP[15:8]);
    reg_rd("R8 chip lo", 8'h21, CHIP[7:0]);
    reg_rd("R8 vendor hi", 8'h23, VEND[15:8]);
    reg_rd("R8 vendor lo", 8'h24, VEND[7:0]);
    reg_wr(8'h20, 8'h00);
    rd_chk("R8 chip write ignored", CHIP[15:8]);
    reg_wr(8'h24, 8'h5A);
    rd_chk("R8 vendor write ignored", VEND[7:0]);
  endtask

  task automatic t_unimpl;
    reg_wr(8'h45, 8'h5A);
    rd_chk("R9 unimpl read", 8'h00);
    put(1'b0, 8'h87);
    rd_chk("R9 key byte as index", 8'h00);
    put(1'b1, 8'hC4);
    chk_exports("R9 unimpl write ignored");
    reg_rd("R9 select untouched", 8'h07, 8'h00);
  endtask

  task automatic t_banks;
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      e_en[d]   = d[0];
      e_base[d] = 16'h1000 * 16'(d + 1) + 16'h0011 * 16'(d + 3);
      e_irq[d]  = 8'(3 + 2 * d);
      reg_wr(8'h30, {7'h55, e_en[d]});
      reg_wr(8'h60, e_base[d][15:8]);
      reg_wr(8'h61, e_base[d][7:0]);
      reg_wr(8'h70, e_irq[d]);
    end
    chk_exports("R7 exports per bank");
    reg_wr(8'h07, 8'h01);
    reg_rd("R6 select readback", 8'h07, 8'h01);
    reg_rd("R7 enable readback", 8'h30, {7'b0, e_en[1]});
    reg_rd("R7 base hi readback", 8'h60, e_base[1][15:8]);
    reg_rd("R7 base lo readback", 8'h61, e_base[1][7:0]);
    reg_rd("R7 irq readback", 8'h70, e_irq[1]);
    // R5: index persists across data accesses
    put(1'b0, 8'h70); put(1'b1, 8'h0B); put(1'b1, 8'h0E);
    e_irq[1] = 8'h0E;
    rd_chk("R5 last write wins", 8'h0E);
    rd_chk("R5 repeat read", 8'h0E);
    chk_exports("R6 other banks intact");
  endtask

  task automatic t_ldn_oob;
    reg_wr(8'h07, 8'h05);
    reg_rd("R6 select full byte", 8'h07, 8'h05);
    reg_wr(8'h60, 8'hEE);
    rd_chk("R10 oob read", 8'h00);
    reg_wr(8'h07, 8'hFF);
    reg_wr(8'h70, 8'h99);
    rd_chk("R10 oob irq read", 8'h00);
    chk_exports("R10 oob write ignored");
  endtask

  task automatic t_lock;
    reg_wr(8'h07, 8'h02);
    put(1'b0, 8'h70);
    put(1'b0, 8'hAA);
    rd_chk("R3 locked after key", 8'hFF);
    put(1'b1, 8'h99);
    chk_exports("R4 locked write ignored");
    put(1'b0, 8'h87);
    rd_chk("R2 one key after lock", 8'hFF);
    put(1'b0, 8'h87);
    reg_rd("R4 irq kept", 8'h70, e_irq[2]);
    reg_rd("R4 select kept", 8'h07, 8'h02);
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      e_en[d] = 1'b0; e_base[d] = 16'h0; e_irq[d] = 8'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_ids();
    t_unimpl();
    t_banks();
    t_ldn_oob();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule